// File: doc/BRIEF.md
# Sequenced Integer Multiply Unit

This unit is the multiply engine of a 32-bit integer execute stage. The caller presents two operands, a 2-bit operation code and a one-cycle start strobe. The unit returns a single result word together with a completion flag.

A low-word product comes from a full-width combinational multiplier and completes in the start cycle. The three high-word forms share one 17x17 signed multiplier. A small sequencer feeds it four half-word pairs on four consecutive cycles and adds the shifted partial products into a 64-bit accumulator. The upper half of the sum is returned in the fourth cycle.

The caller holds the operands and the operation code stable until the completion flag appears. A flush input abandons the operation in progress.

Top module: `imul_top`

## Requirements
- R1: While reset is asserted and directly after it, `busy_o` and `done_o` are 0 and `result_o` is zero.
- R2: Operation code 2'b00 selects the low product. A start with this code, in an idle cycle without flush, raises `done_o` in that same cycle, and `result_o` is bits [31:0] of `a_i*b_i`. `busy_o` stays 0.
- R3: Operation code 2'b01 returns bits [63:32] of the product with both operands taken as two's-complement signed values.
- R4: Operation code 2'b10 returns bits [63:32] of the product of signed `a_i` and unsigned `b_i`.
- R5: Operation code 2'b11 returns bits [63:32] of the product with both operands taken as unsigned values.
- R6: A high-word operation started in cycle t drives `busy_o` high in cycles t+1 to t+3 and `done_o` high only in cycle t+3. It is idle again in t+4.
- R7: `flush_i` high in a busy cycle suppresses `done_o` in that cycle and returns the unit to idle (`busy_o` 0) in the next cycle.
- R8: A start that coincides with `flush_i` is ignored. No `done_o` is raised and `busy_o` stays 0 for either kind of operation.
- R9: A start while `busy_o` is high is ignored. The running operation keeps its completion cycle and its result.
- R10: In every cycle where `done_o` is 0, `result_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request strobe |
| op_i | input | 2 | 00 low, 01 signed high, 10 signed-by-unsigned high, 11 unsigned high |
| a_i | input | 32 | First operand, held until done |
| b_i | input | 32 | Second operand, held until done |
| flush_i | input | 1 | Abort current operation |
| busy_o | output | 1 | Sequencer running a high-word operation |
| done_o | output | 1 | Result valid this cycle |
| result_o | output | 32 | Result word, zero when not done |

## Verification
The operand values 0, 1, -1, 0x7FFFFFFF and 0x80000000 are combined in every pair under each operation code, and random pairs follow. The extreme values show whether each half-word product is sign-extended or zero-extended per operation. The all-ones and minimum-value cases separate the signed, mixed and unsigned high forms, which agree on small positive operands. Flushes are placed on each of the three busy cycles and on the start cycle, and starts are repeated while busy. These tests show whether the sequencer stops cleanly, restarts wrongly, or leaks a completion flag.

// File: rtl/imul_pkg.sv
package imul_pkg;
  localparam int unsigned IMUL_W     = 32;
  localparam int unsigned IMUL_STEPS = 4;

  typedef enum logic [1:0] {
    OP_LO  = 2'b00,
    OP_HSS = 2'b01,
    OP_HSU = 2'b10,
    OP_HUU = 2'b11
  } imul_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } imul_state_e;
endpackage

// File: rtl/imul_opsel.sv
module imul_opsel
  import imul_pkg::*;
(
  input  logic [1:0] op_i,
  output logic       a_sgn_o,
  output logic       b_sgn_o,
  output logic       hi_o
);
  imul_op_e op;

  always_comb begin
    op      = imul_op_e'(op_i);
    a_sgn_o = 1'b0;
    b_sgn_o = 1'b0;
    hi_o    = 1'b1;
    unique case (op)
      OP_LO:  hi_o = 1'b0;
      OP_HSS: begin a_sgn_o = 1'b1; b_sgn_o = 1'b1; end
      OP_HSU: a_sgn_o = 1'b1;
      OP_HUU: ;
      default: hi_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/imul_ppgen.sv
module imul_ppgen #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = 2
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           a_sgn_i,
  input  logic           b_sgn_i,
  input  logic [SW-1:0]  step_i,
  output logic [2*W-1:0] pp_o
);
  localparam int unsigned H  = W / 2;
  localparam int unsigned PW = 2 * H + 2;
  localparam int unsigned XW = 2 * W - PW;
  localparam int unsigned SHW = $clog2(2 * W);

  // half-word slices, each widened to H+1 bits so they read as signed
  logic [1:0][H:0] a_half;
  logic [1:0][H:0] b_half;

  for (genvar g = 0; g < 2; g++) begin : g_half
    if (g == 0) begin : g_lo
      assign a_half[g] = {1'b0, a_i[H-1:0]};
      assign b_half[g] = {1'b0, b_i[H-1:0]};
    end else begin : g_hi
      assign a_half[g] = {a_sgn_i & a_i[W-1], a_i[W-1:H]};
      assign b_half[g] = {b_sgn_i & b_i[W-1], b_i[W-1:H]};
    end
  end

  logic        [H:0]    xa_sel;
  logic        [H:0]    xb_sel;
  logic signed [PW-1:0] xa_w;
  logic signed [PW-1:0] xb_w;
  logic signed [PW-1:0] prod;
  logic        [2*W-1:0] prod_ext;
  logic        [SHW-1:0] shamt;

  always_comb begin
    xa_sel   = a_half[step_i[1]];
    xb_sel   = b_half[step_i[0]];
    xa_w     = signed'({{(PW-H-1){xa_sel[H]}}, xa_sel});
    xb_w     = signed'({{(PW-H-1){xb_sel[H]}}, xb_sel});
    prod     = xa_w * xb_w;
    prod_ext = {{XW{prod[PW-1]}}, prod};
    unique case ({step_i[1], step_i[0]})
      2'b00:   shamt = '0;
      2'b11:   shamt = SHW'(2 * H);
      default: shamt = SHW'(H);
    endcase
    pp_o = prod_ext << shamt;
  end
endmodule

// File: rtl/imul_lomul.sv
module imul_lomul #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o
);
  always_comb p_o = a_i * b_i;
endmodule

// File: rtl/imul_ctrl.sv
module imul_ctrl
  import imul_pkg::*;
#(
  parameter int unsigned STEPS = 4,
  localparam int unsigned SW   = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          hi_i,
  input  logic          flush_i,
  output logic          busy_o,
  output logic          last_o,
  output logic [SW-1:0] step_o,
  output logic          load_o,
  output logic          acc_en_o
);
  imul_state_e st_q, st_d;
  logic [SW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    cnt_en   = 1'b0;
    busy_o   = (st_q == ST_RUN);
    last_o   = busy_o && (cnt_q == SW'(STEPS - 1));
    step_o   = busy_o ? cnt_q : '0;
    load_o   = 1'b0;
    acc_en_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i && hi_i && !flush_i) begin
          st_d     = ST_RUN;
          cnt_d    = SW'(1);
          cnt_en   = 1'b1;
          load_o   = 1'b1;
          acc_en_o = 1'b1;
        end
      end
      ST_RUN: begin
        if (flush_i || last_o) begin
          st_d   = ST_IDLE;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end else begin
          cnt_d    = cnt_q + SW'(1);
          cnt_en   = 1'b1;
          acc_en_o = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/imul_top.sv
module imul_top
  import imul_pkg::*;
#(
  parameter int unsigned W     = IMUL_W,
  parameter int unsigned STEPS = IMUL_STEPS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         flush_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  localparam int unsigned SW = $clog2(STEPS);

  logic a_sgn_live, b_sgn_live, hi_live;
  logic a_sgn_q, b_sgn_q;
  logic a_sgn_use, b_sgn_use;
  logic last, load, acc_en;
  logic [SW-1:0]  step;
  logic [2*W-1:0] pp, acc_q, acc_d, sum;
  logic [W-1:0]   lo_prod;
  logic           done_lo, done_hi;

  imul_opsel u_opsel (
    .op_i    (op_i),
    .a_sgn_o (a_sgn_live),
    .b_sgn_o (b_sgn_live),
    .hi_o    (hi_live)
  );

  imul_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .hi_i     (hi_live),
    .flush_i  (flush_i),
    .busy_o   (busy_o),
    .last_o   (last),
    .step_o   (step),
    .load_o   (load),
    .acc_en_o (acc_en)
  );

  always_comb begin
    a_sgn_use = busy_o ? a_sgn_q : a_sgn_live;
    b_sgn_use = busy_o ? b_sgn_q : b_sgn_live;
  end

  imul_ppgen #(.W(W), .SW(SW)) u_ppgen (
    .a_i     (a_i),
    .b_i     (b_i),
    .a_sgn_i (a_sgn_use),
    .b_sgn_i (b_sgn_use),
    .step_i  (step),
    .pp_o    (pp)
  );

  imul_lomul #(.W(W)) u_lomul (
    .a_i (a_i),
    .b_i (b_i),
    .p_o (lo_prod)
  );

  always_comb begin
    sum     = acc_q + pp;
    acc_d   = load ? pp : sum;
    done_lo = start_i && !busy_o && !flush_i && !hi_live;
    done_hi = last && !flush_i;
    done_o  = done_lo || done_hi;
    if (done_hi)      result_o = sum[2*W-1:W];
    else if (done_lo) result_o = lo_prod;
    else              result_o = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      a_sgn_q <= 1'b0;
      b_sgn_q <= 1'b0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      if (load) begin
        a_sgn_q <= a_sgn_live;
        b_sgn_q <= b_sgn_live;
      end
    end
  end
endmodule

// File: rtl/imul_chk.sv
module imul_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic [1:0]   op_i,
  input logic         flush_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] result_o
);
  // R2
  lo_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !flush_i && op_i == 2'b00) |-> (done_o && !busy_o));

  // R6
  busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(start_i) && !$past(flush_i) && $past(op_i) != 2'b00));

  // R6
  hi_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && busy_o) |-> ($past(busy_o) && $past(busy_o, 2)));

  // R6
  hi_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && busy_o) |=> !busy_o);

  // R7
  flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !busy_o);

  // R7
  flush_nodone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> !done_o);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && !flush_i) |=> busy_o);

  // R10
  zero_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (result_o == '0));
endmodule

bind imul_top imul_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .op_i     (op_i),
  .flush_i  (flush_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/imul_top_bench.sv
`timescale 1ns/1ps
module imul_top_bench;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  op_i;
  logic [31:0] a_i;
  logic [31:0] b_i;
  logic        flush_i;
  logic        busy_o;
  logic        done_o;
  logic [31:0] result_o;

  int    n_run;
  int    n_fail;
  bit    ref_on;
  string cur_req;
  int    ref_cnt;
  logic [31:0] ref_hold;

  imul_top u_imul_top (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .flush_i(flush_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_result(input logic [1:0] op,
                                             input logic [31:0] a,
                                             input logic [31:0] b);
    longint      sa, sb, ub, p;
    logic [63:0] up;
    sa = longint'(signed'(a));
    sb = longint'(signed'(b));
    ub = longint'({32'b0, b});
    up = {32'b0, a} * {32'b0, b};
    case (op)
      2'b00:   return up[31:0];
      2'b01:   begin p = sa * sb; return p[63:32]; end
      2'b10:   begin p = sa * ub; return p[63:32]; end
      default: return up[63:32];
    endcase
  endfunction

  // behavioural model, compared on every falling edge
  always @(negedge clk) begin
    logic        e_busy, e_done;
    logic [31:0] e_res;
    if (ref_on) begin
      e_busy = (ref_cnt != 0);
      e_done = 1'b0;
      e_res  = '0;
      if (ref_cnt == 0) begin
        if (start_i && !flush_i) begin
          if (op_i == 2'b00) begin
            e_done = 1'b1;
            e_res  = ref_result(op_i, a_i, b_i);
          end else begin
            ref_hold = ref_result(op_i, a_i, b_i);
            ref_cnt  = 1;
          end
        end
      end else begin
        if (ref_cnt == 3 && !flush_i) begin
          e_done = 1'b1;
          e_res  = ref_hold;
        end
        if (flush_i || ref_cnt == 3) ref_cnt = 0;
        else ref_cnt = ref_cnt + 1;
      end
      check(cur_req, "busy", {31'b0, busy_o}, {31'b0, e_busy});
      check(cur_req, "done", {31'b0, done_o}, {31'b0, e_done});
      check(cur_req, "result", result_o, e_res);
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic run_op(input logic [1:0] op, input logic [31:0] a,
                        input logic [31:0] b);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    tick();
    start_i = 1'b0;
    if (op != 2'b00) repeat (3) tick();
  endtask

  task automatic run_flush(input logic [1:0] op, input logic [31:0] a,
                           input logic [31:0] b, input int k);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    if (k == 0) flush_i = 1'b1;
    tick();
    start_i = 1'b0;
    flush_i = 1'b0;
    if (k > 0) begin
      repeat (k - 1) tick();
      flush_i = 1'b1;
      tick();
      flush_i = 1'b0;
    end
    tick();
  endtask

  function automatic string op_tag(input logic [1:0] op);
    case (op)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_run++;
    $display("FAIL R6 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] corner [5];
    n_run = 0; n_fail = 0; ref_on = 1'b0; ref_cnt = 0; ref_hold = '0;
    cur_req = "R1";
    rst_n = 1'b0; start_i = 1'b0; op_i = 2'b00; a_i = '0; b_i = '0; flush_i = 1'b0;
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001; corner[2] = 32'hFFFF_FFFF;
    corner[3] = 32'h7FFF_FFFF; corner[4] = 32'h8000_0000;
    repeat (3) @(posedge clk);
    #2;
    // R1 state held in reset
    check("R1", "busy in reset", {31'b0, busy_o}, 32'd0);
    check("R1", "done in reset", {31'b0, done_o}, 32'd0);
    check("R1", "result in reset", result_o, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    ref_on = 1'b1;
    tick();
    tick();

    // R2 R3 R4 R5: corner pairs for every operation code
    for (int op = 0; op < 4; op++) begin
      cur_req = op_tag(2'(op));
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          run_op(2'(op), corner[i], corner[j]);
    end
    // random pairs, operation codes interleaved
    for (int n = 0; n < 200; n++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      cur_req = op_tag(op);
      run_op(op, $urandom, $urandom);
    end

    // R6 back-to-back high-word operations, then a low one right after
    cur_req = "R6";
    run_op(2'b01, 32'h1234_5678, 32'h9ABC_DEF0);
    run_op(2'b11, 32'hDEAD_BEEF, 32'hFFFF_0001);
    run_op(2'b00, 32'h0001_0000, 32'h0001_0000);

    // R7 flush on each busy cycle
    cur_req = "R7";
    for (int k = 1; k <= 3; k++) run_flush(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, k);

    // R8 start together with flush
    cur_req = "R8";
    run_flush(2'b00, 32'h0000_0003, 32'h0000_0005, 0);
    run_flush(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);

    // R9 start repeated while busy, including the completion cycle
    cur_req = "R9";
    start_i = 1'b1; op_i = 2'b11; a_i = 32'hFFFF_FFFF; b_i = 32'hFFFF_FFFF;
    tick();
    start_i = 1'b0;
    tick();
    start_i = 1'b1;
    tick();
    tick();
    start_i = 1'b0;
    tick();

    // R10 idle cycles with moving operands
    cur_req = "R10";
    for (int n = 0; n < 20; n++) begin
      a_i = $urandom; b_i = $urandom; op_i = 2'($urandom_range(0, 3));
      tick();
    end

    ref_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule